// File: doc/BRIEF.md
# ADC Result Sequencer

This block sits between an analog-to-digital converter and the software-visible result storage. Each completed conversion arrives as a 12-bit unsigned sample with a one-cycle strobe. The block formats the sample into a 16-bit word and writes it into one of sixteen result registers. It keeps a 4-bit pointer to the register that will take the next result, a completion flag per register, and a flag that marks the end of a sequence.

A single configuration write sets three things: the output justification, the number of conversions per sequence, and the placement mode. In indexed mode, each sequence fills registers from index 0 upward and the pointer returns to 0 when the sequence ends. In ring mode, the pointer survives sequence boundaries and wraps from the last register to the first. Only an abort or a new start resets it. Ring mode also holds the compare-enable gate low, so downstream compare logic stays idle. A continuous-scan input lets one sequence follow the next without a new start.

Top module: `adc_result_seq`

## Requirements
- R1: When the justify bit is 0, a stored sample occupies bits 15:4 and bits 3:0 are zero. When the justify bit is 1, the sample occupies bits 11:0 and bits 15:12 are zero.
- R2: The sequence length is the 4-bit length field, read as an unsigned number. A field value of 0 means 16 conversions. After reset the field is 4.
- R3: In indexed mode (mode bit 0), the k-th result of a sequence (k from 0) goes to register k. Once the selected number of results is stored, `seq_done` rises and `conv_cnt` returns to 0. With continuous scan off, further strobes then leave every register unchanged.
- R4: In ring mode (mode bit 1), `conv_cnt` is not reset at the end of a sequence. Results go to consecutive registers, and index 15 is followed by index 0.
- R5: A start pulse clears `conv_cnt`, every completion flag and `seq_done`, so the first result after a start lands in register 0.
- R6: An abort pulse, or any configuration write, clears `conv_cnt` and stops the sequence. Strobes are then ignored until the next start. Abort or configuration write takes priority over a start in the same cycle.
- R7: A register's completion flag sets on the cycle after that register is written. A read of index i with the fast-clear input high clears flag i. A read with fast-clear low changes no flag.
- R8: `cmp_en` is low whenever ring mode is configured, and high otherwise.
- R9: `conv_cnt` always equals the index of the register that the next accepted result will be written to.
- R10: With continuous scan on, storing continues past the end of a sequence with `seq_done` held high. In indexed mode the next result goes to register 0. In ring mode the pointer keeps advancing.
- R11: After reset, all registers read zero, all flags are low, `conv_cnt` is 0, `seq_done` is low and `cmp_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe (also aborts) |
| cfg_right | input | 1 | 1 = right-justify, 0 = left-justify |
| cfg_len | input | 4 | Conversions per sequence, 0 means 16 |
| cfg_fifo | input | 1 | 1 = ring placement, 0 = indexed placement |
| cont_scan | input | 1 | Continue into the next sequence without a start |
| seq_start | input | 1 | Begin a new sequence |
| seq_abort | input | 1 | Stop the current sequence |
| conv_done | input | 1 | Conversion result strobe |
| conv_data | input | 12 | Unsigned conversion sample |
| rd_en | input | 1 | Result register read strobe |
| rd_idx | input | 4 | Index of the register being read |
| fast_clr | input | 1 | Reads clear the completion flag |
| result_bus | output | 256 | Sixteen 16-bit result registers, register i at bits 16*i+15:16*i |
| conv_cnt | output | 4 | Index of the next register to be written |
| done_flags | output | 16 | Per-register completion flags |
| seq_done | output | 1 | Sequence complete |
| cmp_en | output | 1 | Compare-enable gate, low in ring mode |

## Verification
Several properties are checked by assertions on every cycle. Aborts and configuration writes must clear the pointer, and a start must clear the pointer and the flags. A written register must get its flag, the zero bits of both justifications must hold, ring mode must wrap from 15 to 0, and indexed mode must end a sequence with the pointer at 0. Other behaviour can only be shown by the bench's scenarios. These include the exact placement order across all sixteen length values, the default length of four, and the fact that strobes are ignored after a sequence or an abort. The bench also covers pointer persistence across ring-mode sequences, continuous-scan wraparound, and the contrast between reads with and without fast clear.

// File: rtl/adc_result_seq.sv
module adc_result_seq #(
  parameter int NREG = 16,
  parameter int SW = 12,
  parameter int RW = 16,
  localparam int CW = $clog2(NREG),
  localparam int NW = CW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_right,
  input  logic [CW-1:0]      cfg_len,
  input  logic               cfg_fifo,
  input  logic               cont_scan,
  input  logic               seq_start,
  input  logic               seq_abort,
  input  logic               conv_done,
  input  logic [SW-1:0]      conv_data,
  input  logic               rd_en,
  input  logic [CW-1:0]      rd_idx,
  input  logic               fast_clr,
  output logic [NREG*RW-1:0] result_bus,
  output logic [CW-1:0]      conv_cnt,
  output logic [NREG-1:0]    done_flags,
  output logic               seq_done,
  output logic               cmp_en
);

  localparam logic [CW-1:0] RESET_LEN = CW'(4);

  logic          right_q, fifo_q, active_q, seqdone_q;
  logic [CW-1:0] len_q, cnt_q;
  logic [NW-1:0] nstored_q, seq_len;
  logic [NREG-1:0] flags_q;
  logic [RW-1:0] regs [NREG];

  logic          stop, take, last;
  logic [CW-1:0] cnt_inc;
  logic [RW-1:0] fmt;

  assign stop    = seq_abort | cfg_we;
  assign take    = conv_done & active_q & ~stop & ~seq_start;
  assign seq_len = (len_q == '0) ? NW'(NREG) : {1'b0, len_q};
  assign last    = take && ((nstored_q + NW'(1)) == seq_len);
  assign cnt_inc = (cnt_q == CW'(NREG - 1)) ? '0 : cnt_q + CW'(1);
  assign fmt     = right_q ? RW'(conv_data) : (RW'(conv_data) << (RW - SW));

  assign conv_cnt   = cnt_q;
  assign done_flags = flags_q;
  assign seq_done   = seqdone_q;
  assign cmp_en     = ~fifo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      right_q <= 1'b0;
      fifo_q  <= 1'b0;
      len_q   <= RESET_LEN;
    end else if (cfg_we) begin
      right_q <= cfg_right;
      fifo_q  <= cfg_fifo;
      len_q   <= cfg_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      nstored_q <= '0;
      seqdone_q <= 1'b0;
    end else if (stop) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      nstored_q <= '0;
    end else if (seq_start) begin
      active_q  <= 1'b1;
      cnt_q     <= '0;
      nstored_q <= '0;
      seqdone_q <= 1'b0;
    end else if (take) begin
      if (last) begin
        nstored_q <= '0;
        seqdone_q <= 1'b1;
        if (!cont_scan) active_q <= 1'b0;
        cnt_q <= fifo_q ? cnt_inc : '0;
      end else begin
        nstored_q <= nstored_q + NW'(1);
        cnt_q     <= cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (seq_start && !stop) begin
      flags_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (take && cnt_q == CW'(i))
          flags_q[i] <= 1'b1;
        else if (rd_en && fast_clr && rd_idx == CW'(i))
          flags_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (take) begin
      regs[cnt_q] <= fmt;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign result_bus[g*RW +: RW] = regs[g];
  end

  p_abort_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (conv_cnt == '0) && !active_q);

  p_start_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !stop) |=> (conv_cnt == '0) && (done_flags == '0) && !seq_done);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> done_flags[$past(cnt_q)]);

  p_right_hi_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && right_q) |=> ((regs[$past(cnt_q)] >> SW) == '0));

  p_left_lo_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !right_q) |=> ((regs[$past(cnt_q)] << SW) == '0));

  p_ring_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fifo_q && cnt_q == CW'(NREG - 1)) |=> (conv_cnt == '0));

  p_seq_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !fifo_q) |=> (conv_cnt == '0) && seq_done);

  p_cmp_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_fifo) |=> !cmp_en);

endmodule

// File: tb/sim_adc_result_seq.sv
module sim_adc_result_seq;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_right = 0, cfg_fifo = 0, cont_scan = 0;
  logic [3:0] cfg_len = 0, rd_idx = 0;
  logic seq_start = 0, seq_abort = 0, conv_done = 0, rd_en = 0, fast_clr = 0;
  logic [11:0] conv_data = 0;
  logic [255:0] result_bus;
  logic [3:0] conv_cnt;
  logic [15:0] done_flags;
  logic seq_done, cmp_en;
  int errors = 0, checks = 0;
  logic [255:0] snap;

  always #5 clk = ~clk;

  adc_result_seq u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_right(cfg_right),
    .cfg_len(cfg_len), .cfg_fifo(cfg_fifo), .cont_scan(cont_scan), .seq_start(seq_start),
    .seq_abort(seq_abort), .conv_done(conv_done), .conv_data(conv_data), .rd_en(rd_en),
    .rd_idx(rd_idx), .fast_clr(fast_clr), .result_bus(result_bus), .conv_cnt(conv_cnt),
    .done_flags(done_flags), .seq_done(seq_done), .cmp_en(cmp_en));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(logic [11:0] d, logic r);
    return r ? {4'h0, d} : {d, 4'h0};
  endfunction

  function automatic logic [15:0] reg_at(int i);
    return result_bus[i*16 +: 16];
  endfunction

  task automatic configure(logic r, logic [3:0] len, logic f);
    @(negedge clk); cfg_we = 1; cfg_right = r; cfg_len = len; cfg_fifo = f;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic start_seq();
    @(negedge clk); seq_start = 1;
    @(negedge clk); seq_start = 0;
  endtask

  task automatic abort_seq();
    @(negedge clk); seq_abort = 1;
    @(negedge clk); seq_abort = 0;
  endtask

  task automatic conv(logic [11:0] d);
    @(negedge clk); conv_done = 1; conv_data = d;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic rd(logic [3:0] idx, logic fc);
    @(negedge clk); rd_en = 1; rd_idx = idx; fast_clr = fc;
    @(negedge clk); rd_en = 0; fast_clr = 0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 cnt", 32'(conv_cnt), 0);
    chk("R11 flags", 32'(done_flags), 0);
    chk("R11 seq_done", 32'(seq_done), 0);
    chk("R11 cmp_en", 32'(cmp_en), 1);
    chk("R11 regs", 32'(result_bus != 0), 0);

    // R2 default length of four, left justified
    start_seq();
    for (int k = 0; k < 4; k++) begin
      conv(12'(12'hA10 + k));
      chk("R2 cnt", 32'(conv_cnt), (k == 3) ? 0 : k + 1);
    end
    chk("R2 seq_done", 32'(seq_done), 1);
    conv(12'h777);
    chk("R2 reg4 untouched", 32'(reg_at(4)), 0);
    for (int k = 0; k < 4; k++) chk("R1 left", 32'(reg_at(k)), 32'(fmt(12'(12'hA10 + k), 0)));

    // R3 R9 R1 sweep of every length and both justifications
    for (int r = 0; r < 2; r++) begin
      for (int len = 0; len < 16; len++) begin
        int L;
        L = (len == 0) ? 16 : len;
        configure(r[0], 4'(len), 0);
        start_seq();
        chk("R5 start flags", 32'(done_flags), 0);
        for (int k = 0; k < L; k++) begin
          conv(12'((len * 37 + k * 101 + r * 7) & 12'hFFF));
          chk("R9 cnt", 32'(conv_cnt), (k + 1 == L) ? 0 : k + 1);
          chk("R3 seq_done", 32'(seq_done), (k + 1 == L) ? 1 : 0);
        end
        for (int k = 0; k < L; k++)
          chk("R3 R1 placement", 32'(reg_at(k)),
              32'(fmt(12'((len * 37 + k * 101 + r * 7) & 12'hFFF), r[0])));
        chk("R7 flags", 32'(done_flags), (L == 16) ? 32'hFFFF : (32'(1) << L) - 1);
        snap = result_bus;
        conv(12'h5A5);
        chk("R3 ignored after end", 32'(result_bus == snap), 1);
      end
    end

    // R8 R4 ring mode without continuous scan
    configure(1, 4, 1);
    chk("R8 cmp_en ring", 32'(cmp_en), 0);
    start_seq();
    for (int k = 0; k < 4; k++) conv(12'(k + 1));
    chk("R4 cnt kept at end", 32'(conv_cnt), 4);
    chk("R4 seq_done", 32'(seq_done), 1);
    start_seq();
    chk("R5 start clears cnt", 32'(conv_cnt), 0);

    // R4 R10 ring mode, continuous, wrap past 15
    cont_scan = 1;
    for (int k = 0; k < 20; k++) begin
      conv(12'(12'h300 + k));
      chk("R4 cnt", 32'(conv_cnt), (k + 1) % 16);
      chk("R4 reg", 32'(reg_at(k % 16)), 32'(fmt(12'(12'h300 + k), 1)));
    end
    chk("R10 seq_done ring", 32'(seq_done), 1);

    // R10 indexed continuous scan
    configure(1, 3, 0);
    chk("R8 cmp_en indexed", 32'(cmp_en), 1);
    start_seq();
    for (int k = 0; k < 7; k++) begin
      conv(12'(12'h100 + k));
      chk("R10 cnt", 32'(conv_cnt), (k + 1) % 3);
      chk("R10 reg", 32'(reg_at(k % 3)), 32'(fmt(12'(12'h100 + k), 1)));
    end
    chk("R10 seq_done", 32'(seq_done), 1);
    cont_scan = 0;

    // R6 abort mid-sequence
    configure(1, 8, 0);
    start_seq();
    conv(12'h011); conv(12'h022);
    chk("R6 cnt before", 32'(conv_cnt), 2);
    abort_seq();
    chk("R6 abort cnt", 32'(conv_cnt), 0);
    snap = result_bus;
    conv(12'h0EE);
    chk("R6 ignored after abort", 32'(result_bus == snap), 1);
    chk("R6 cnt stays", 32'(conv_cnt), 0);

    // R6 configuration write aborts
    start_seq();
    conv(12'h033);
    configure(1, 8, 0);
    chk("R6 cfg cnt", 32'(conv_cnt), 0);
    snap = result_bus;
    conv(12'h0DD);
    chk("R6 ignored after cfg", 32'(result_bus == snap), 1);

    // R6 abort wins over start
    @(negedge clk); seq_abort = 1; seq_start = 1;
    @(negedge clk); seq_abort = 0; seq_start = 0;
    snap = result_bus;
    conv(12'h0CC);
    chk("R6 abort priority", 32'(result_bus == snap), 1);

    // R7 fast clear behaviour
    configure(0, 4, 0);
    start_seq();
    for (int k = 0; k < 4; k++) conv(12'(k));
    chk("R7 flags set", 32'(done_flags), 32'hF);
    rd(1, 0);
    chk("R7 no fast clear", 32'(done_flags), 32'hF);
    rd(1, 1);
    chk("R7 fast clear", 32'(done_flags), 32'hD);
    rd(3, 1);
    chk("R7 fast clear 3", 32'(done_flags), 32'h5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule